// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is a small register-mapped test function placed behind a bus endpoint. A host uses it to check both the endpoint's data path and its interrupt path. The host programs addresses, a byte count and interrupt settings into a flat register file. It then writes a command word, and the engine carries out that one action.

The memory actions are: fetch a host buffer, fill a host buffer with a known pattern, or move one host buffer to another. They go out through a word-wide request/acknowledge memory port. The interrupt test drives a single-cycle interrupt request that carries a type code and a vector. Each outcome is reported in its own status bit, and a checksum lets the host confirm the data that was moved.

The host port is a plain synchronous write strobe with a word index. Read data is combinational from the addressed register.

Top module: `ep_test_engine`

## Requirements
- R1: The pattern register (index 0) returns on read exactly the last value the host wrote to it.
- R2: Command register (index 1) bits: bit 0 legacy interrupt, bit 1 MSI interrupt, bit 2 MSI-X interrupt, bit 3 read host buffer, bit 4 write host buffer, bit 5 copy host buffer. When several bits are set, only the lowest set bit is acted on. Reading the register returns the last accepted command.
- R3: Status register (index 2) bits: 0 read ok, 1 read fail, 2 write ok, 3 write fail, 4 copy ok, 5 copy fail, 6 interrupt raised, 7 bad source address, 8 bad destination address. Every accepted command write, including a write of zero, clears the status register.
- R4: A read fetches ceil(size/4) words, starting at the source address (index 3) and stepping by 4. The size register is index 5. The XOR of all fetched words is placed in the checksum register (index 6), and status bit 0 is set.
- R5: A write stores word k (k counted from 0) as the value k+1 at the destination address (index 4) plus 4k. The XOR of the stored words goes to the checksum register, and status bit 2 is set.
- R6: A copy alternates one fetch from the source and one store to the destination per word. The checksum register ends up holding the XOR of the copied words, and status bit 4 is set.
- R7: An address that is zero or whose low two bits are non-zero is invalid. In that case the matching bad-address bit (7 for the source, 8 for the destination) and the action's fail bit are set, and no memory request is issued.
- R8: An error response stops the action at that word. The action's fail bit is set, and no further requests follow.
- R9: An interrupt command drives irq_req for exactly one cycle. irq_type is 0 for legacy, 1 for MSI and 2 for MSI-X, and irq_vec holds the interrupt number register (index 8). Status bit 6 is set.
- R10: The interrupt number must be 0 for legacy, 1 to 32 for MSI, and 1 to 2048 for MSI-X. Any other number, or a type code of 3, raises no interrupt and leaves status bit 6 clear.
- R11: When a read, write or copy ends, whether it succeeds or fails, an interrupt is raised. Its type comes from the interrupt type register (index 7) and its vector from the number register, under the rule in R10. A size of zero completes at once with the ok bit set.
- R12: A command write that arrives while an action is still running is ignored. It does not change the status register or the command readback, and it starts nothing.
- R13: mem_req, once raised, stays high until mem_ack, and its address, direction and write data stay constant while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | RAW | Register word index |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data of addressed register |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = store, 0 = fetch |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | DW | Store data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completion carries an error |
| mem_rdata | input | DW | Fetched data, valid with mem_ack |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_type | output | 2 | 0 legacy, 1 MSI, 2 MSI-X |
| irq_vec | output | NUMW | Interrupt number |

## Verification
An interrupt command is captured at the clock edge that takes the host write, and irq_req is high during the very next cycle. The bench therefore samples irq_req, irq_type and irq_vec at the falling edge that ends its write task. Memory actions take two cycles per request with the bench's one-wait-state memory, plus one check cycle and one interrupt cycle. The bench allows a fixed settling window that is far longer than this before it reads status, checksum or memory, so no check depends on the exact duration. Register reads are combinational and are sampled one time unit after the index is driven at a falling edge.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam int REG_PAT  = 0;
  localparam int REG_CMD  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_SRC  = 3;
  localparam int REG_DST  = 4;
  localparam int REG_SIZE = 5;
  localparam int REG_CHK  = 6;
  localparam int REG_ITYP = 7;
  localparam int REG_INUM = 8;

  localparam int CMDW = 6;
  localparam int STW  = 9;

  localparam int ST_IRQ     = 6;
  localparam int ST_BAD_SRC = 7;
  localparam int ST_BAD_DST = 8;

  localparam logic [1:0] KIND_LEG  = 2'd0;
  localparam logic [1:0] KIND_MSI  = 2'd1;
  localparam logic [1:0] KIND_MSIX = 2'd2;

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_CP, OP_IRQ} op_e;
  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD, S_WR, S_IRQ} state_e;
endpackage

// File: rtl/ept_regs.sv
module ept_regs
  import ept_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NUMW = 12,
  parameter int RAW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [RAW-1:0]  host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic [CMDW-1:0] cmd_q,
  input  logic [STW-1:0]  status_q,
  input  logic [DW-1:0]   chk_q,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic [AW-1:0]   size_o,
  output logic [1:0]      itype_o,
  output logic [NUMW-1:0] inum_o
);
  logic [DW-1:0]   pat_q, pat_n;
  logic [AW-1:0]   src_n, dst_n, size_n;
  logic [1:0]      itype_n;
  logic [NUMW-1:0] inum_n;

  always_comb begin
    pat_n   = pat_q;
    src_n   = src_o;
    dst_n   = dst_o;
    size_n  = size_o;
    itype_n = itype_o;
    inum_n  = inum_o;
    if (host_we) begin
      case (int'(host_addr))
        REG_PAT:  pat_n   = host_wdata;
        REG_SRC:  src_n   = host_wdata[AW-1:0];
        REG_DST:  dst_n   = host_wdata[AW-1:0];
        REG_SIZE: size_n  = host_wdata[AW-1:0];
        REG_ITYP: itype_n = host_wdata[1:0];
        REG_INUM: inum_n  = host_wdata[NUMW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= '0;
      src_o   <= '0;
      dst_o   <= '0;
      size_o  <= '0;
      itype_o <= '0;
      inum_o  <= '0;
    end else if (host_we) begin
      pat_q   <= pat_n;
      src_o   <= src_n;
      dst_o   <= dst_n;
      size_o  <= size_n;
      itype_o <= itype_n;
      inum_o  <= inum_n;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (int'(host_addr))
      REG_PAT:  host_rdata = pat_q;
      REG_CMD:  host_rdata = DW'(cmd_q);
      REG_STAT: host_rdata = DW'(status_q);
      REG_SRC:  host_rdata = DW'(src_o);
      REG_DST:  host_rdata = DW'(dst_o);
      REG_SIZE: host_rdata = DW'(size_o);
      REG_CHK:  host_rdata = chk_q;
      REG_ITYP: host_rdata = DW'(itype_o);
      REG_INUM: host_rdata = DW'(inum_o);
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ept_seq.sv
module ept_seq
  import ept_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NUMW     = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [CMDW-1:0] cmd_wdata,
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [AW-1:0]   size_i,
  input  logic [1:0]      itype_i,
  input  logic [NUMW-1:0] inum_i,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [DW-1:0]   mem_rdata,
  output logic            irq_req,
  output logic [1:0]      irq_type,
  output logic [NUMW-1:0] irq_vec,
  output logic            busy,
  output logic [CMDW-1:0] cmd_q,
  output logic [STW-1:0]  status_q,
  output logic [DW-1:0]   chk_q
);
  state_e          st_q, st_n;
  op_e             op_q, op_n;
  logic [1:0]      kind_q, kind_n;
  logic [AW-1:0]   cnt_q, cnt_n, off_q, off_n;
  logic [DW-1:0]   buf_q, buf_n, chk_n;
  logic [CMDW-1:0] cmd_n;
  logic [STW-1:0]  status_n;
  logic            bad_src, bad_dst, irq_ok;
  logic [DW-1:0]   pattern;

  function automatic logic addr_bad(input logic [AW-1:0] a);
    return (a == '0) || (a[1:0] != 2'b00);
  endfunction

  function automatic int ok_bit(input op_e o);
    return (o == OP_RD) ? 0 : (o == OP_WR) ? 2 : 4;
  endfunction

  assign bad_src = (op_q != OP_WR) && addr_bad(src_i);
  assign bad_dst = (op_q != OP_RD) && addr_bad(dst_i);
  assign pattern = DW'(off_q >> 2) + DW'(1);

  always_comb begin
    case (kind_q)
      KIND_LEG:  irq_ok = (inum_i == '0);
      KIND_MSI:  irq_ok = (inum_i != '0) && (inum_i <= NUMW'(MSI_MAX));
      KIND_MSIX: irq_ok = (inum_i != '0) && (inum_i <= NUMW'(MSIX_MAX));
      default:   irq_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_n = st_q; op_n = op_q; kind_n = kind_q; cnt_n = cnt_q; off_n = off_q;
    buf_n = buf_q; chk_n = chk_q; cmd_n = cmd_q; status_n = status_q;
    case (st_q)
      S_IDLE: if (cmd_wr) begin
        cmd_n    = cmd_wdata;
        status_n = '0;
        kind_n   = itype_i;
        if (cmd_wdata[0])      begin op_n = OP_IRQ; kind_n = KIND_LEG;  st_n = S_IRQ; end
        else if (cmd_wdata[1]) begin op_n = OP_IRQ; kind_n = KIND_MSI;  st_n = S_IRQ; end
        else if (cmd_wdata[2]) begin op_n = OP_IRQ; kind_n = KIND_MSIX; st_n = S_IRQ; end
        else if (cmd_wdata[3]) begin op_n = OP_RD; st_n = S_CHK; end
        else if (cmd_wdata[4]) begin op_n = OP_WR; st_n = S_CHK; end
        else if (cmd_wdata[5]) begin op_n = OP_CP; st_n = S_CHK; end
      end
      S_CHK: begin
        if (bad_src || bad_dst) begin
          status_n[ok_bit(op_q) + 1] = 1'b1;
          status_n[ST_BAD_SRC]       = bad_src;
          status_n[ST_BAD_DST]       = bad_dst;
          st_n = S_IRQ;
        end else begin
          chk_n = '0;
          off_n = '0;
          cnt_n = AW'(({1'b0, size_i} + (AW+1)'(3)) >> 2);
          if (size_i == '0) begin
            status_n[ok_bit(op_q)] = 1'b1;
            st_n = S_IRQ;
          end else begin
            st_n = (op_q == OP_WR) ? S_WR : S_RD;
          end
        end
      end
      S_RD: if (mem_ack) begin
        if (mem_err) begin
          status_n[ok_bit(op_q) + 1] = 1'b1;
          st_n = S_IRQ;
        end else begin
          chk_n = chk_q ^ mem_rdata;
          if (op_q == OP_CP) begin
            buf_n = mem_rdata;
            st_n  = S_WR;
          end else begin
            off_n = off_q + AW'(4);
            cnt_n = cnt_q - AW'(1);
            if (cnt_q == AW'(1)) begin
              status_n[ok_bit(op_q)] = 1'b1;
              st_n = S_IRQ;
            end
          end
        end
      end
      S_WR: if (mem_ack) begin
        if (mem_err) begin
          status_n[ok_bit(op_q) + 1] = 1'b1;
          st_n = S_IRQ;
        end else begin
          if (op_q == OP_WR) chk_n = chk_q ^ pattern;
          off_n = off_q + AW'(4);
          cnt_n = cnt_q - AW'(1);
          if (cnt_q == AW'(1)) begin
            status_n[ok_bit(op_q)] = 1'b1;
            st_n = S_IRQ;
          end else begin
            st_n = (op_q == OP_CP) ? S_RD : S_WR;
          end
        end
      end
      S_IRQ: begin
        if (irq_ok) status_n[ST_IRQ] = 1'b1;
        st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; op_q <= OP_RD; kind_q <= '0; cnt_q <= '0; off_q <= '0;
      buf_q <= '0; chk_q <= '0; cmd_q <= '0; status_q <= '0;
    end else begin
      st_q <= st_n; op_q <= op_n; kind_q <= kind_n; cnt_q <= cnt_n; off_q <= off_n;
      buf_q <= buf_n; chk_q <= chk_n; cmd_q <= cmd_n; status_q <= status_n;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign mem_req   = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = ((st_q == S_RD) ? src_i : dst_i) + off_q;
  assign mem_wdata = (op_q == OP_CP) ? buf_q : pattern;
  assign irq_req   = (st_q == S_IRQ) && irq_ok;
  assign irq_type  = kind_q;
  assign irq_vec   = inum_i;
endmodule

// File: rtl/ep_test_engine.sv
module ep_test_engine
  import ept_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NUMW     = 12,
  parameter int RAW      = 4,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic [RAW-1:0]  host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [DW-1:0]   mem_rdata,
  output logic            irq_req,
  output logic [1:0]      irq_type,
  output logic [NUMW-1:0] irq_vec
);
  logic            cmd_wr, busy;
  logic [CMDW-1:0] cmd_q;
  logic [STW-1:0]  status_q;
  logic [DW-1:0]   chk_q;
  logic [AW-1:0]   src, dst, size;
  logic [1:0]      itype;
  logic [NUMW-1:0] inum;

  assign cmd_wr = host_we && (int'(host_addr) == REG_CMD);

  ept_regs #(.AW(AW), .DW(DW), .NUMW(NUMW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_q(cmd_q),
    .status_q(status_q), .chk_q(chk_q), .src_o(src), .dst_o(dst),
    .size_o(size), .itype_o(itype), .inum_o(inum)
  );

  ept_seq #(.AW(AW), .DW(DW), .NUMW(NUMW), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(host_wdata[CMDW-1:0]),
    .src_i(src), .dst_i(dst), .size_i(size), .itype_i(itype), .inum_i(inum),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .irq_req(irq_req), .irq_type(irq_type), .irq_vec(irq_vec),
    .busy(busy), .cmd_q(cmd_q), .status_q(status_q), .chk_q(chk_q)
  );
endmodule

// File: rtl/ept_checker.sv
module ept_checker #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NUMW     = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            irq_req,
  input logic [1:0]      irq_type,
  input logic [NUMW-1:0] irq_vec,
  input logic            busy,
  input logic            cmd_wr,
  input logic [5:0]      cmd_q
);
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  assert_leg_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_type == 2'd0) |-> (irq_vec == '0));
  assert_msi_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_type == 2'd1) |-> (irq_vec != '0 && irq_vec <= NUMW'(MSI_MAX)));
  assert_msix_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_type == 2'd2) |-> (irq_vec != '0 && irq_vec <= NUMW'(MSIX_MAX)));
  assert_no_type3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_type != 2'd3));
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr != '0));
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));
  assert_no_req_with_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !mem_req);
endmodule

bind ep_test_engine ept_checker #(.AW(AW), .DW(DW), .NUMW(NUMW), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_req(irq_req), .irq_type(irq_type),
  .irq_vec(irq_vec), .busy(busy), .cmd_wr(cmd_wr), .cmd_q(cmd_q)
);

// File: tb/test_ep_test_engine.sv
module test_ep_test_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_req;
  logic [1:0]  irq_type;
  logic [11:0] irq_vec;

  logic [31:0] mem [64];
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          nreq = 0, nirq = 0, n_chk = 0, n_fail = 0, cyc = 0;
  logic [1:0]  last_type = '0;
  logic [11:0] last_vec = '0;

  always #4 clk = ~clk;

  ep_test_engine i_ep_test_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .irq_req(irq_req),
    .irq_type(irq_type), .irq_vec(irq_vec)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_err   = err_en && (mem_addr == err_addr);

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        nreq <= nreq + 1;
        if (mem_we && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
      end
      if (irq_req) begin
        nirq <= nirq + 1; last_type <= irq_type; last_vec <= irq_vec;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act %0d cycles exp below 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = 4'(a);
    #1 d = host_rdata;
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  task automatic setup_mem(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] size);
    wr(3, src); wr(4, dst); wr(5, size); wr(7, 1); wr(8, 5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R3 reset irq_req", 32'(irq_req), 0);
    check("R13 reset mem_req", 32'(mem_req), 0);
    rd(2, d); check("R3 reset status", d, 0);
    rd(6, d); check("R4 reset checksum", d, 0);
  endtask

  task automatic t_pattern();
    logic [31:0] d;
    wr(0, 32'hA5C3_0F96); rd(0, d); check("R1 pattern a", d, 32'hA5C3_0F96);
    wr(0, 32'h0000_0001); rd(0, d); check("R1 pattern b", d, 32'h1);
  endtask

  task automatic t_read();
    logic [31:0] d, x;
    int n0, i0;
    x = 0;
    for (int k = 0; k < 4; k++) x ^= mem[16 + k];
    setup_mem(32'h40, 32'h80, 16);
    n0 = nreq; i0 = nirq;
    wr(1, 32'h08); settle();
    rd(2, d); check("R4 read status", d, 32'h41);
    rd(6, d); check("R4 read checksum", d, x);
    check("R4 read requests", 32'(nreq - n0), 4);
    check("R11 read irq count", 32'(nirq - i0), 1);
    check("R11 read irq type", 32'(last_type), 1);
    check("R11 read irq vec", 32'(last_vec), 5);
    n0 = nreq; wr(5, 6); wr(1, 32'h08); settle();
    check("R4 ceil size requests", 32'(nreq - n0), 2);
    n0 = nreq; wr(5, 0); wr(1, 32'h08); settle();
    rd(2, d); check("R11 size zero status", d, 32'h41);
    check("R11 size zero no request", 32'(nreq - n0), 0);
  endtask

  task automatic t_write();
    logic [31:0] d;
    setup_mem(32'h40, 32'h80, 20);
    wr(1, 32'h10); settle();
    rd(2, d); check("R5 write status", d, 32'h44);
    rd(6, d); check("R5 write checksum", d, 32'h1);
    for (int k = 0; k < 5; k++) check("R5 write memory", mem[32 + k], 32'(k + 1));
  endtask

  task automatic t_copy();
    logic [31:0] d, x;
    x = mem[16] ^ mem[17] ^ mem[18];
    setup_mem(32'h40, 32'hA0, 12);
    wr(1, 32'h20); settle();
    rd(2, d); check("R6 copy status", d, 32'h50);
    rd(6, d); check("R6 copy checksum", d, x);
    for (int k = 0; k < 3; k++) check("R6 copy memory", mem[40 + k], mem[16 + k]);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    int n0;
    n0 = nreq;
    setup_mem(32'h0, 32'h80, 8); wr(1, 32'h08); settle();
    rd(2, d); check("R7 zero source", d, 32'hC2);
    setup_mem(32'h40, 32'h82, 8); wr(1, 32'h10); settle();
    rd(2, d); check("R7 misaligned destination", d, 32'h148);
    setup_mem(32'h0, 32'h81, 8); wr(1, 32'h20); settle();
    rd(2, d); check("R7 both bad on copy", d, 32'h1E0);
    check("R7 no requests", 32'(nreq - n0), 0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    int n0;
    setup_mem(32'h40, 32'h80, 16);
    err_en = 1'b1; err_addr = 32'h48; n0 = nreq;
    wr(1, 32'h08); settle();
    err_en = 1'b0;
    rd(2, d); check("R8 error status", d, 32'h42);
    check("R8 stop at error", 32'(nreq - n0), 3);
  endtask

  task automatic irq_case(input string req, input logic [31:0] cmd, input logic [31:0] num,
                          input bit fire, input logic [1:0] typ);
    logic [31:0] d;
    wr(8, num);
    wr(1, cmd);
    #1;
    check(req, 32'(irq_req), 32'(fire));
    if (fire) begin
      check(req, 32'(irq_type), 32'(typ));
      check(req, 32'(irq_vec), num);
    end
    @(negedge clk); #1;
    check(req, 32'(irq_req), 0);
    rd(2, d); check(req, d, fire ? 32'h40 : 32'h0);
  endtask

  task automatic t_irq();
    irq_case("R9 legacy 0", 32'h01, 0, 1'b1, 2'd0);
    irq_case("R10 legacy 1 refused", 32'h01, 1, 1'b0, 2'd0);
    irq_case("R9 MSI 32", 32'h02, 32, 1'b1, 2'd1);
    irq_case("R10 MSI 33 refused", 32'h02, 33, 1'b0, 2'd1);
    irq_case("R10 MSI 0 refused", 32'h02, 0, 1'b0, 2'd1);
    irq_case("R9 MSI-X 2048", 32'h04, 2048, 1'b1, 2'd2);
    irq_case("R10 MSI-X 2049 refused", 32'h04, 2049, 1'b0, 2'd2);
    irq_case("R2 lowest bit MSI over MSI-X", 32'h06, 7, 1'b1, 2'd1);
  endtask

  task automatic t_priority_busy();
    logic [31:0] d;
    int i0;
    setup_mem(32'h40, 32'hC0, 8);
    mem[48] = 32'h1234;
    wr(1, 32'h18); settle();
    rd(2, d); check("R2 read wins over write", d, 32'h41);
    check("R2 write not done", mem[48], 32'h1234);
    rd(1, d); check("R2 command readback", d, 32'h18);
    wr(7, 3); i0 = nirq;
    wr(1, 32'h08); settle();
    rd(2, d); check("R10 type code 3 no irq", d, 32'h01);
    check("R10 type code 3 count", 32'(nirq - i0), 0);
    setup_mem(32'h40, 32'h80, 32);
    i0 = nirq;
    wr(1, 32'h08);
    wr(1, 32'h04);
    settle();
    rd(2, d); check("R12 busy command ignored status", d, 32'h41);
    rd(1, d); check("R12 busy command readback", d, 32'h08);
    check("R12 one irq only", 32'(nirq - i0), 1);
    check("R12 irq type of read", 32'(last_type), 1);
    wr(1, 0);
    rd(2, d); check("R3 zero command clears status", d, 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'h9E37_0000 + 32'(k * 7919);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pattern();
    t_read();
    t_write();
    t_copy();
    t_bad_addr();
    t_err();
    t_irq();
    t_priority_busy();
    finish_run();
  end
endmodule